// File: doc/BRIEF.md
# Byte-Wide Erasable One-Time-Programmable Memory Model

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory with one active-low chip enable and one active-low output enable. A small register array stores the bytes. An erase input stands in for ultraviolet exposure and returns every bit to 1. Programming can only clear bits. Every clock, a control decoder turns the enable pins, a programming-voltage-present flag and a high-voltage flag on address line 9 into one of seven operating modes. A state register holds that mode, and the outputs are driven from it on the following cycle.

The modes are STANDBY (power-down), READ, OUTDIS (output disable), PGM (program pulse), VERIFY (program verify), INHIBIT (program inhibit) and SIG (identifier). There is no sequencing between modes, so any mode can follow any other. Each cycle the next mode is chosen from the inputs alone. One transition has a side effect: leaving PGM because the chip enable went high. That edge stores the bitwise AND of the addressed byte and the data that was latched while the pulse was low. The data bus is modelled as a value `data_out` plus an enable `data_oe`. Several models can share a bus by gating on `data_oe`.

Top module: `otp_byte_mem`

## Requirements
- R1: With ce_n=0, oe_n=0 and a9_hv=0 sampled at a clock edge (READ), after that edge data_oe=1, low_power=0 and data_out equals the byte stored at index addr[IDX_W-1:0].
- R2: With ce_n=0, oe_n=1 and vpp_on=0 (OUTDIS), after the edge data_oe=0 and low_power=0.
- R3: With ce_n=1 and vpp_on=0 (STANDBY), after the edge data_oe=0 and low_power=1. STANDBY is also the reset state.
- R4: Reset, or erase high at one clock edge, sets every byte to 0xFF by that edge. Erase overrides a write at the same edge.
- R5: With vpp_on=1, oe_n=1 and ce_n=0 (PGM), the address and data are latched each cycle. At the first edge where ce_n is sampled high after PGM, the byte at the latched index becomes its old value AND the latched data.
- R6: Programming never turns a 0 bit into a 1. Writing 0xFF leaves a byte unchanged.
- R7: With vpp_on=1, ce_n=1 and oe_n=0 (VERIFY), after the edge data_oe=1, low_power=0 and data_out equals the stored byte at the address index.
- R8: With vpp_on=1 and ce_n=oe_n=1 (INHIBIT), no byte changes, data_oe=0 and low_power=1.
- R9: With ce_n=0, oe_n=0 and a9_hv=1 (SIG), data_oe=1 and data_out is 0x97 when addr[0]=0 and 0x50 when addr[0]=1. If any address bit other than bit 0 and bit 9 is 1, data_out is 0xFF.
- R10: Address bits at or above IDX_W do not select storage. Addresses that differ only in those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It also erases the array |
| erase | input | 1 | Bulk erase: all bytes become 0xFF |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Data to program |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| vpp_on | input | 1 | Programming voltage present |
| a9_hv | input | 1 | High voltage present on address line 9 |
| data_out | output | 8 | Data bus value; 0x00 when not driven |
| data_oe | output | 1 | Bus drive enable |
| low_power | output | 1 | Power-down indicator |

## Verification
The held mode decides `data_oe` and `low_power` directly. A wrong mode therefore shows at the ports one cycle after the pins that chose it, whether it is bus drive in power-down, silence in read, or the identifier in place of array data. A wrong array byte stays hidden until that byte is read or verified. The bench reads the programmed bytes again after every write, after inhibit and after erase, so a bad AND merge, a missed write or a write through inhibit is caught in the next read cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] MFR_CODE   = 8'h97;
    localparam logic [BYTE_W-1:0] DEV_CODE   = 8'h50;
    localparam logic [BYTE_W-1:0] ERASED     = 8'hFF;
    localparam logic [BYTE_W-1:0] IDLE_BUS   = 8'h00;
    localparam int HV_ADDR_BIT = 9;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUTDIS,
        M_PGM,
        M_VERIFY,
        M_INHIBIT,
        M_SIG
    } mode_e;

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_on,
    input  logic  a9_hv,
    output mode_e next_mode
);

    // Pin decode; the state register in the top holds the result.
    always_comb begin
        unique case ({ce_n, oe_n})
            2'b00:   next_mode = a9_hv  ? M_SIG     : M_READ;
            2'b01:   next_mode = vpp_on ? M_PGM     : M_OUTDIS;
            2'b10:   next_mode = vpp_on ? M_VERIFY  : M_STANDBY;
            2'b11:   next_mode = vpp_on ? M_INHIBIT : M_STANDBY;
            default: next_mode = M_STANDBY;
        endcase
    end

endmodule

// File: rtl/otp_array.sv
module otp_array
    import otp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [BYTE_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= ERASED;
            else if (erase)
                word_q <= ERASED;
            else if (wr_en && (wr_idx == IDX_W'(w)))
                word_q <= word_q & wr_data;
        end
        assign words[w] = word_q;
    end

    assign rd_data = words[rd_idx];

    // R4: the edge after erase shows an erased byte at any read index
    a_r4_erase_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (rd_data == ERASED));

    // R6: with a steady read index and no erase, no bit may go from 0 to 1
    a_r6_no_bit_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(erase) && (rd_idx == $past(rd_idx)))
            |-> ((rd_data & ~$past(rd_data)) == '0));

endmodule

// File: rtl/otp_out_mux.sv
module otp_out_mux
    import otp_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  mode_e             mode_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              low_power
);

    localparam logic [ADDR_W-1:0] SIG_FREE =
        ADDR_W'(1) | (ADDR_W'(1) << HV_ADDR_BIT);

    logic                sig_clean;
    logic [BYTE_W-1:0]   sig_byte;

    assign sig_clean = ((addr_q & ~SIG_FREE) == '0);
    assign sig_byte  = !sig_clean ? ERASED : (addr_q[0] ? DEV_CODE : MFR_CODE);

    always_comb begin
        data_out  = IDLE_BUS;
        data_oe   = 1'b0;
        low_power = 1'b0;
        unique case (mode_q)
            M_READ, M_VERIFY: begin
                data_out = rd_data;
                data_oe  = 1'b1;
            end
            M_SIG: begin
                data_out = sig_byte;
                data_oe  = 1'b1;
            end
            M_STANDBY, M_INHIBIT: low_power = 1'b1;
            M_OUTDIS, M_PGM:      ;
            default:              ;
        endcase
    end

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
    import otp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              low_power
);

    mode_e             next_mode;
    mode_e             mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  pend_idx;
    logic [BYTE_W-1:0] pend_data;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;

    otp_mode_dec u_dec (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_on    (vpp_on),
        .a9_hv     (a9_hv),
        .next_mode (next_mode)
    );

    // State register; PGM also latches the pending write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= M_STANDBY;
            addr_q    <= '0;
            pend_idx  <= '0;
            pend_data <= ERASED;
        end else begin
            mode_q <= next_mode;
            addr_q <= addr;
            if (next_mode == M_PGM) begin
                pend_idx  <= addr[IDX_W-1:0];
                pend_data <= data_in;
            end
        end
    end

    // Transition PGM -> (ce_n high) commits the write.
    assign wr_en = (mode_q == M_PGM) && ce_n;

    otp_array #(.DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_idx  (pend_idx),
        .wr_data (pend_data),
        .rd_idx  (addr_q[IDX_W-1:0]),
        .rd_data (rd_data)
    );

    otp_out_mux #(.ADDR_W(ADDR_W)) u_out (
        .mode_q    (mode_q),
        .addr_q    (addr_q),
        .rd_data   (rd_data),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .low_power (low_power)
    );

    // R1: the bus is driven only after output enable was low
    a_r1_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!oe_n));

    // R3: enable high without programming voltage means power-down
    a_r3_power_down: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n && !vpp_on) |-> (low_power && !data_oe));

    // R8: inhibit pins keep the bus quiet
    a_r8_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n && oe_n && vpp_on) |-> (low_power && !data_oe));

    // R9: identifier mode only shows the two codes or the blank byte
    a_r9_sig_codes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !oe_n && a9_hv)
            |-> (data_oe && (data_out == MFR_CODE || data_out == DEV_CODE
                             || data_out == ERASED)));

endmodule

// File: tb/otp_byte_mem_test.sv
module otp_byte_mem_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              erase = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        data_in = '0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              vpp_on = 1'b0;
    logic              a9_hv = 1'b0;
    logic [7:0]        data_out;
    logic              data_oe;
    logic              low_power;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_byte_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .erase(erase), .addr(addr),
        .data_in(data_in), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on),
        .a9_hv(a9_hv), .data_out(data_out), .data_oe(data_oe),
        .low_power(low_power)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive pins at a falling edge, then wait one cycle so the result shows.
    task automatic drive(logic ce, logic oe, logic vpp, logic hv,
                         logic [ADDR_W-1:0] a, logic [7:0] d);
        ce_n = ce; oe_n = oe; vpp_on = vpp; a9_hv = hv; addr = a; data_in = d;
        @(negedge clk);
    endtask

    task automatic read_check(string req, logic [ADDR_W-1:0] a);
        drive(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
        check(req, {7'd0, data_oe}, 8'h01);
        check(req, {7'd0, low_power}, 8'h00);
        check(req, data_out, model[a % DEPTH]);
    endtask

    task automatic program_byte(logic [ADDR_W-1:0] a, logic [7:0] d);
        drive(1'b0, 1'b1, 1'b1, 1'b0, a, d);
        drive(1'b1, 1'b1, 1'b1, 1'b0, a, d);   // rising enable commits
        model[a % DEPTH] = model[a % DEPTH] & d;
        drive(1'b1, 1'b1, 1'b0, 1'b0, a, d);
    endtask

    task automatic t_reset;
        check("R3 reset low_power", {7'd0, low_power}, 8'h01);
        check("R3 reset data_oe", {7'd0, data_oe}, 8'h00);
        read_check("R4 reset erased", 12'h003);
    endtask

    task automatic t_program;
        program_byte(12'h003, 8'h5A);
        read_check("R5 program 5A", 12'h003);
        program_byte(12'h003, 8'hF0);
        read_check("R5 AND merge", 12'h003);
        check("R5 merge value", data_out, 8'h50);
        program_byte(12'h003, 8'hFF);
        read_check("R6 ones keep zeros", 12'h003);
        check("R6 value", data_out, 8'h50);
        read_check("R5 neighbour untouched", 12'h004);
    endtask

    task automatic t_alias;
        read_check("R10 alias high bits", 12'h013);
        check("R10 alias value", data_out, 8'h50);
        program_byte(12'h207, 8'h0F);
        read_check("R10 alias write", 12'h007);
        check("R10 alias write value", data_out, 8'h0F);
    endtask

    task automatic t_modes;
        drive(1'b1, 1'b0, 1'b1, 1'b0, 12'h003, 8'h00);
        check("R7 verify data", data_out, 8'h50);
        check("R7 verify oe", {7'd0, data_oe}, 8'h01);
        check("R7 verify lp", {7'd0, low_power}, 8'h00);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 12'h003, 8'h00);
        check("R2 outdis oe", {7'd0, data_oe}, 8'h00);
        check("R2 outdis lp", {7'd0, low_power}, 8'h00);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 12'h003, 8'h00);
        check("R3 standby oe", {7'd0, data_oe}, 8'h00);
        check("R3 standby lp", {7'd0, low_power}, 8'h01);
    endtask

    task automatic t_inhibit;
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b0, 12'h005, 8'h00);
            check("R8 inhibit oe", {7'd0, data_oe}, 8'h00);
            check("R8 inhibit lp", {7'd0, low_power}, 8'h01);
        end
        read_check("R8 inhibit no write", 12'h005);
        check("R8 inhibit value", data_out, 8'hFF);
    endtask

    task automatic t_signature;
        drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'h00);
        check("R9 manufacturer code", data_out, 8'h97);
        check("R9 sig oe", {7'd0, data_oe}, 8'h01);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h001, 8'h00);
        check("R9 device code", data_out, 8'h50);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h200, 8'h00);
        check("R9 bit9 ignored", data_out, 8'h97);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h041, 8'h00);
        check("R9 stray bit blank", data_out, 8'hFF);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 12'h800, 8'h00);
        check("R9 top bit blank", data_out, 8'hFF);
    endtask

    task automatic t_erase;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 8'h00);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        read_check("R4 erase byte 3", 12'h003);
        read_check("R4 erase byte 7", 12'h007);
    endtask

    task automatic t_erase_beats_write;
        drive(1'b0, 1'b1, 1'b1, 1'b0, 12'h009, 8'h00);
        ce_n = 1'b1; erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 12'h009, 8'h00);
        read_check("R4 erase over write", 12'h009);
        check("R4 erase over write value", data_out, 8'hFF);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_alias();
        t_modes();
        t_inhibit();
        t_signature();
        t_erase();
        t_erase_beats_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule